// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Change Event and Stop Wakeup

This block is a small general-purpose I/O port of `W` pins (four by default) for a low-power microcontroller. A write-only direction register makes each pin an output or an input on its own. An output latch drives the pins that are outputs, always push-pull. A read path returns the synchronized pad level of every pin, whatever its direction. Register writes arrive as one-cycle strobes with data from the surrounding CPU logic.

Pad inputs cross a two-flop synchronizer. A change detector then compares the synchronized value with its value one cycle earlier. For each pin whose change-enable bit is set, a level change latches a bit in a sticky status register. Any newly latched change raises an event flag. The flag becomes an interrupt request when the interrupt enable is set, and a hold-release request when the hold enable is set. Accepting the interrupt (`irq_ack`) clears the flag and leaves the status bits alone. A separate falling-edge path, gated by its own stop mask, gives a one-cycle stop-mode wake pulse.

The event logic is a three-state machine. `EV_ARM` is entered at reset and holds detection off while the synchronizer fills. `EV_ARM -> EV_QUIET` is taken once `SYNC_STAGES+1` clock edges have passed. `EV_QUIET -> EV_PEND` is taken when a new enabled change is latched. `EV_PEND -> EV_QUIET` is taken on `irq_ack` in a cycle with no new change. `EV_PEND` stays put when a new change arrives, with or without an acknowledge.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, all pins are inputs (`pad_oe` = 0), the output latch is 0, and `status`, `event_flag`, `irq_req`, `hold_release` and `stop_wake` are all 0.
- R2: A write to the direction register with bit i = 0 makes pin i an output (`pad_oe[i]`=1, driving `pad_out[i]` from the output latch). Bit i = 1 makes pin i an input. The direction register has no read path.
- R3: `pin_rdata` returns the pad levels two clock edges after they settle, for input and output pins alike.
- R4: A level change on pin i with change-enable bit i set makes `status[i]`=1 on the third clock edge after the pad changes. A change on a pin whose enable bit is clear sets nothing.
- R5: Status bits are sticky. They clear only on `stat_clr`, on a write to the change-enable mask, or on reset.
- R6: When a clear (`stat_clr` or a mask write) and a newly latched enabled change fall on the same edge, the status afterwards holds exactly the new change bits.
- R7: A newly latched change sets `event_flag`. `irq_ack` clears it and leaves `status` unchanged. A new change on the same edge as `irq_ack` keeps the flag set.
- R8: `irq_req` equals `event_flag` AND interrupt-enable (`evt_cfg` bit 1). `hold_release` equals `event_flag` AND hold-enable (`evt_cfg` bit 0).
- R9: A falling edge on pin i with stop-mask bit i set gives a one-cycle `stop_wake` pulse on the same edge on which a change would latch. Rising edges and unmasked pins give none.
- R10: No change is latched and no wake is given during the first `SYNC_STAGES+1` clock edges after reset.
- R11: Switching an output pin to input when its latch differs from the external level is detected as an ordinary change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Direction register write strobe |
| mode_wdata | input | W | Direction data, 1 = input, 0 = output |
| dout_we | input | 1 | Output latch write strobe |
| dout_wdata | input | W | Output latch data |
| chg_en_we | input | 1 | Change-enable mask write strobe (also clears status) |
| chg_en_wdata | input | W | Change-enable mask data |
| stop_en_we | input | 1 | Stop-wake falling-edge mask write strobe |
| stop_en_wdata | input | W | Stop-wake mask data |
| evt_cfg_we | input | 1 | Event configuration write strobe |
| evt_cfg_wdata | input | 2 | Bit 0 hold enable, bit 1 interrupt enable |
| stat_clr | input | 1 | Clear change status command |
| irq_ack | input | 1 | Interrupt accepted, clears event flag |
| pad_in | input | W | Pad levels seen at the pins |
| pad_out | output | W | Output latch driven to pads |
| pad_oe | output | W | Per-pin output enable |
| pin_rdata | output | W | Synchronized pin levels |
| status | output | W | Sticky pin-change status |
| event_flag | output | 1 | Port event pending |
| irq_req | output | 1 | Interrupt request |
| hold_release | output | 1 | Hold-mode release request |
| stop_wake | output | 1 | Stop-mode wake pulse |

## Verification
The bench sweeps every change mask against every toggle pattern. A design that ignored the mask, or latched one cycle early or late, shows a wrong status at the sampled edge. Clears and acknowledges are placed on the very edge a new change latches: a design where the clear wins would lose the event, and one where the acknowledge wipes status would empty the sticky register. Every stop mask is swept against every falling and rising pattern, which catches a wake on rising edges or a pulse that stretches past one cycle. The arming window is tested with a mask written during reset warm-up, so a design that trusts its reset-valued synchronizer would report a false change.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

    // Event sequencer states
    typedef enum logic [1:0] {
        EV_ARM   = 2'd0,
        EV_QUIET = 2'd1,
        EV_PEND  = 2'd2
    } evt_state_t;

    // Event configuration bit positions
    localparam int CFG_HOLD_BIT = 0;
    localparam int CFG_IRQ_BIT  = 1;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] chg_mask,
    input  logic [W-1:0] stop_mask,
    input  logic         clr_req,
    output logic [W-1:0] status,
    output logic         any_new,
    output logic         wake
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] fall_hit;
    logic         wake_q;

    always_comb begin
        hit      = armed ? ((cur ^ prev_q) & chg_mask) : '0;
        fall_hit = armed ? ((prev_q & ~cur) & stop_mask) : '0;
        any_new  = |hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            status <= '0;
            wake_q <= 1'b0;
        end else begin
            prev_q <= cur;
            wake_q <= |fall_hit;
            if (clr_req) status <= hit;
            else         status <= status | hit;
        end
    end

    assign wake = wake_q;

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((status & $past(status)) == $past(status)));

    // R6
    clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !any_new) |=> (status == '0));

    // R9
    wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(|stop_mask));

    // R10
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wake);

endmodule

// File: rtl/gpio_evt_fsm.sv
module gpio_evt_fsm
    import gpio_wake_pkg::*;
#(
    parameter int ARM_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_new,
    input  logic ack,
    output logic armed,
    output logic event_flag
);
    localparam int CW = $clog2(ARM_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(ARM_CYC - 1);

    evt_state_t     st_q, st_d;
    logic [CW-1:0]  cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EV_ARM:   if (cnt_q == LAST)       st_d = EV_QUIET;
            EV_QUIET: if (any_new)             st_d = EV_PEND;
            EV_PEND:  if (ack && !any_new)     st_d = EV_QUIET;
            default:                           st_d = EV_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= EV_ARM;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == EV_ARM) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        armed      = 1'b1;
        event_flag = 1'b0;
        unique case (st_q)
            EV_ARM:   armed = 1'b0;
            EV_QUIET: event_flag = 1'b0;
            EV_PEND:  event_flag = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !any_new) |=> !event_flag);

    // R7
    new_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_new |=> event_flag);

    // R10
    arm_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !event_flag);

endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
    import gpio_wake_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [W-1:0] mode_wdata,
    input  logic         dout_we,
    input  logic [W-1:0] dout_wdata,
    input  logic         chg_en_we,
    input  logic [W-1:0] chg_en_wdata,
    input  logic         stop_en_we,
    input  logic [W-1:0] stop_en_wdata,
    input  logic         evt_cfg_we,
    input  logic [1:0]   evt_cfg_wdata,
    input  logic         stat_clr,
    input  logic         irq_ack,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pin_rdata,
    output logic [W-1:0] status,
    output logic         event_flag,
    output logic         irq_req,
    output logic         hold_release,
    output logic         stop_wake
);
    localparam int ARM_CYC = SYNC_STAGES + 1;

    logic [W-1:0] mode_q;
    logic [W-1:0] dout_q;
    logic [W-1:0] chg_en_q;
    logic [W-1:0] stop_en_q;
    logic [1:0]   cfg_q;
    logic [W-1:0] sync_val;
    logic         armed;
    logic         any_new;
    logic         clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '1;
            dout_q    <= '0;
            chg_en_q  <= '0;
            stop_en_q <= '0;
            cfg_q     <= '0;
        end else begin
            if (mode_we)    mode_q    <= mode_wdata;
            if (dout_we)    dout_q    <= dout_wdata;
            if (chg_en_we)  chg_en_q  <= chg_en_wdata;
            if (stop_en_we) stop_en_q <= stop_en_wdata;
            if (evt_cfg_we) cfg_q     <= evt_cfg_wdata;
        end
    end

    assign clr_req = stat_clr | chg_en_we;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (sync_val)
    );

    gpio_change_det #(.W(W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .cur       (sync_val),
        .chg_mask  (chg_en_q),
        .stop_mask (stop_en_q),
        .clr_req   (clr_req),
        .status    (status),
        .any_new   (any_new),
        .wake      (stop_wake)
    );

    gpio_evt_fsm #(.ARM_CYC(ARM_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_new    (any_new),
        .ack        (irq_ack),
        .armed      (armed),
        .event_flag (event_flag)
    );

    always_comb begin
        pad_out      = dout_q;
        pad_oe       = ~mode_q;
        pin_rdata    = sync_val;
        irq_req      = event_flag & cfg_q[CFG_IRQ_BIT];
        hold_release = event_flag & cfg_q[CFG_HOLD_BIT];
    end

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (pad_oe == ~$past(mode_wdata)));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(pad_oe));

    // R8
    req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || hold_release) |-> event_flag);

endmodule

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_we = 0, dout_we = 0, chg_en_we = 0, stop_en_we = 0, evt_cfg_we = 0;
    logic [W-1:0] mode_wdata = '0, dout_wdata = '0, chg_en_wdata = '0, stop_en_wdata = '0;
    logic [1:0]   evt_cfg_wdata = '0;
    logic         stat_clr = 0, irq_ack = 0;
    logic [W-1:0] ext = 4'b1010;
    logic [W-1:0] pad_in, pad_out, pad_oe, pin_rdata, status;
    logic         event_flag, irq_req, hold_release, stop_wake;
    int           checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_wake_port #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .dout_we(dout_we), .dout_wdata(dout_wdata),
        .chg_en_we(chg_en_we), .chg_en_wdata(chg_en_wdata),
        .stop_en_we(stop_en_we), .stop_en_wdata(stop_en_wdata),
        .evt_cfg_we(evt_cfg_we), .evt_cfg_wdata(evt_cfg_wdata),
        .stat_clr(stat_clr), .irq_ack(irq_ack),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_rdata(pin_rdata), .status(status), .event_flag(event_flag),
        .irq_req(irq_req), .hold_release(hold_release), .stop_wake(stop_wake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; the register loads on the following posedge
    task automatic wr(input int sel, input logic [W-1:0] v);
        case (sel)
            0: begin mode_we = 1;    mode_wdata = v;      end
            1: begin dout_we = 1;    dout_wdata = v;      end
            2: begin chg_en_we = 1;  chg_en_wdata = v;    end
            3: begin stop_en_we = 1; stop_en_wdata = v;   end
            default: begin evt_cfg_we = 1; evt_cfg_wdata = v[1:0]; end
        endcase
        @(negedge clk);
        mode_we = 0; dout_we = 0; chg_en_we = 0; stop_en_we = 0; evt_cfg_we = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; @(negedge clk); irq_ack = 0;
    endtask

    task automatic pulse_clr();
        stat_clr = 1; @(negedge clk); stat_clr = 0;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 status", status, 0);
        chk("R1 flags", {event_flag, irq_req, hold_release, stop_wake}, 0);
        // R10: mask written during warm-up; pads 1010 differ from reset sync value
        chg_en_we = 1; chg_en_wdata = 4'hF; stop_en_we = 1; stop_en_wdata = 4'hF;
        @(negedge clk);
        chg_en_we = 0; stop_en_we = 0;
        repeat (5) begin
            chk("R10 no wake in warm-up", stop_wake, 0);
            @(negedge clk);
        end
        chk("R10 status after warm-up", status, 0);
        chk("R10 flag after warm-up", event_flag, 0);

        // R4 R7 R8: every change mask against every toggle pattern
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                logic [W-1:0] e;
                wr(4, W'(m));
                wr(2, W'(m));
                pulse_ack();
                chk("R5 mask write clears", status, 0);
                ext = ext ^ W'(p);
                repeat (3) @(negedge clk);
                e = W'(m) & W'(p);
                chk("R4 status", status, e);
                chk("R7 flag", event_flag, (e != 0));
                chk("R8 irq_req", irq_req, (e != 0) && m[1]);
                chk("R8 hold_release", hold_release, (e != 0) && m[0]);
            end
        end

        // R5 R6 R7 collision cases
        wr(2, 4'hF); pulse_ack();
        ext[0] = ~ext[0];
        repeat (3) @(negedge clk);
        chk("R4 bit0", status, 4'b0001);
        pulse_ack();
        chk("R7 ack keeps status", status, 4'b0001);
        chk("R7 ack clears flag", event_flag, 0);
        repeat (2) @(negedge clk);
        chk("R5 sticky", status, 4'b0001);
        ext[1] = ~ext[1];
        repeat (2) @(negedge clk);
        stat_clr = 1; irq_ack = 1;
        @(negedge clk);
        stat_clr = 0; irq_ack = 0;
        chk("R6 clear vs change", status, 4'b0010);
        chk("R7 ack vs change", event_flag, 1);
        pulse_ack();
        chk("R7 ack status kept", status, 4'b0010);
        pulse_clr();
        chk("R5 clear", status, 0);
        ext[2] = ~ext[2];
        repeat (2) @(negedge clk);
        chg_en_we = 1; chg_en_wdata = 4'hF;
        @(negedge clk);
        chg_en_we = 0;
        chk("R6 mask write vs change", status, 4'b0100);

        // R2 R3: outputs drive pads, read path sees them
        ext = 4'b0101;
        repeat (4) @(negedge clk);
        wr(1, 4'b1010);
        wr(0, 4'b0000);
        chk("R2 oe all out", pad_oe, 4'hF);
        chk("R2 pad_out", pad_out, 4'b1010);
        repeat (2) @(negedge clk);
        chk("R3 readback out pins", pin_rdata, 4'b1010);
        wr(0, 4'b0011);
        chk("R2 mixed oe", pad_oe, 4'b1100);
        repeat (2) @(negedge clk);
        chk("R3 readback mixed", pin_rdata, 4'b1001);
        wr(0, 4'b0000);
        repeat (4) @(negedge clk);
        // R11: switch to input with latch differing from external level
        wr(2, 4'hF); pulse_ack();
        wr(0, 4'hF);
        repeat (3) @(negedge clk);
        chk("R11 switch detected", status, 4'hF);
        chk("R11 flag", event_flag, 1);
        chk("R3 readback inputs", pin_rdata, 4'b0101);

        // R9: every stop mask against every fall pattern
        wr(2, 4'h0);
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                ext = 4'hF;
                repeat (4) @(negedge clk);
                wr(3, W'(s));
                ext = ~W'(f);
                repeat (3) @(negedge clk);
                chk("R9 wake on fall", stop_wake, ((s & f) != 0));
                @(negedge clk);
                chk("R9 one-cycle pulse", stop_wake, 0);
                ext = 4'hF;
                repeat (3) @(negedge clk);
                chk("R9 no wake on rise", stop_wake, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule